// File: doc/BRIEF.md
# SIMT Divergent Branch Mask Sequencer

This block steers a 32-lane SIMT warp through two-way branches. On each branch strobe it combines the per-lane predicate with the current active mask. That gives a ballot of the active lanes whose predicate is true. From the ballot the block decides whether the warp agrees on the branch or splits.

When all active lanes agree, the warp keeps its mask and only one side runs. When they disagree, the block pushes a reconvergence entry and runs the predicate-true lanes first. On a path-end strobe it switches to the remaining lanes. On the second path-end strobe it restores the exact mask that was saved.

Lane write-back enables follow the active mask. The block does not model the datapath, instruction fetch or program counters. Nesting is bounded by a small reconvergence stack, and pushing past its depth raises a sticky error flag.

Top module: `simt_branch_seq`

## Requirements
- R1: After reset `active_mask_o` is all ones, `depth_o` is 0 and `overflow_o` is 0.
- R2: `ballot_o` bit i is 1 exactly when lane i is active and `pred_i` bit i is 1. It is combinational, in the same cycle as `pred_i`.
- R3: `lane_we_o` equals `active_mask_o` in every cycle, so masked lanes never write back.
- R4: A branch is uniform when the ballot is zero or equals the active mask. In that cycle `uniform_o` is 1. Lanes outside the active mask do not affect this decision. After a uniform branch the mask and the depth are unchanged.
- R5: On a divergent branch with `depth_o` below 4, the next cycle's mask equals the ballot (the predicate-true set runs first) and `depth_o` rises by 1.
- R6: A path-end strobe while the top entry is in its first phase switches the mask to the lanes that were active at the branch with a false predicate. The depth is unchanged.
- R7: A path-end strobe while the top entry is in its second phase pops the entry. It restores the mask exactly as saved, including lanes that were inactive before the branch.
- R8: The stack holds 4 entries. A divergent branch at depth 4 does not push and leaves the mask unchanged. It sets `overflow_o`, which stays set until reset.
- R9: A path-end strobe at depth 0 is ignored. When branch and path-end strobes arrive in the same cycle, path-end is applied and the branch is ignored.
- R10: A divergent branch occupies the sum of both path lengths. The pre-branch mask returns only after the second path-end strobe, never after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| branch_i | input | 1 | Branch strobe, one cycle |
| pred_i | input | 32 | Per-lane branch predicate |
| path_end_i | input | 1 | Current path finished, one cycle |
| active_mask_o | output | 32 | Active lane mask |
| lane_we_o | output | 32 | Per-lane write-back enable |
| ballot_o | output | 32 | Active lanes with true predicate |
| uniform_o | output | 1 | Branch this cycle is warp-uniform |
| depth_o | output | 3 | Reconvergence stack occupancy |
| overflow_o | output | 1 | Sticky stack overflow error |

## Verification
`ballot_o` and `uniform_o` are combinational, so the bench samples them one time unit after driving the inputs and before the clock edge. The mask, depth and overflow results are registered and land on the first rising edge after a strobe. The bench drives each strobe on a falling edge, waits for the next rising edge, and samples just after it. That is the same edge at which the lane enables change. The cost check counts sampled cycles per phase rather than timing wall-clock intervals.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;
endpackage

// File: rtl/simt_vote.sv
module simt_vote #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] active_i,
  output logic [LANES-1:0] ballot_o,
  output logic             uniform_o
);
  logic [LANES-1:0] taken, not_taken;
  assign taken     = pred_i & active_i;
  assign not_taken = ~pred_i & active_i;
  assign ballot_o  = taken;
  // all active lanes agree when one side is empty
  assign uniform_o = (taken == '0) || (not_taken == '0);
endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LANES-1:0] push_saved_i,
  input  logic [LANES-1:0] push_pending_i,
  input  logic             pop_i,
  input  logic             flip_i,
  output logic [LANES-1:0] top_saved_o,
  output logic [LANES-1:0] top_pending_o,
  output phase_e           top_phase_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [CW-1:0]                count_q;
  logic [DEPTH-1:0][LANES-1:0]  saved_flat, pend_flat;
  logic [DEPTH-1:0]             phase_flat;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [LANES-1:0] saved_q, pend_q;
    phase_e           phase_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        saved_q <= '0;
        pend_q  <= '0;
        phase_q <= PH_A;
      end else if (push_i && count_q == CW'(k)) begin
        saved_q <= push_saved_i;
        pend_q  <= push_pending_i;
        phase_q <= PH_A;
      end else if (flip_i && count_q == CW'(k + 1)) begin
        phase_q <= PH_B;
      end
    end
    assign saved_flat[k] = saved_q;
    assign pend_flat[k]  = pend_q;
    assign phase_flat[k] = phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    count_q <= '0;
    else if (push_i && !full_o)     count_q <= count_q + CW'(1);
    else if (pop_i && !empty_o)     count_q <= count_q - CW'(1);
  end

  always_comb begin
    top_saved_o   = '0;
    top_pending_o = '0;
    top_phase_o   = PH_A;
    for (int k = 0; k < DEPTH; k++) begin
      if (count_q == CW'(k + 1)) begin
        top_saved_o   = saved_flat[k];
        top_pending_o = pend_flat[k];
        top_phase_o   = phase_e'(phase_flat[k]);
      end
    end
  end

  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
endmodule

// File: rtl/simt_branch_seq.sv
module simt_branch_seq
  import simt_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             branch_i,
  input  logic [LANES-1:0] pred_i,
  input  logic             path_end_i,
  output logic [LANES-1:0] active_mask_o,
  output logic [LANES-1:0] lane_we_o,
  output logic [LANES-1:0] ballot_o,
  output logic             uniform_o,
  output logic [CW-1:0]    depth_o,
  output logic             overflow_o
);
  logic [LANES-1:0] active_q, active_d, ballot;
  logic [LANES-1:0] top_saved, top_pending;
  phase_e           top_phase;
  logic             agree, full, empty;
  logic             do_br, do_end, divergent, push, pop, flip, ovf_q;

  simt_vote #(.LANES(LANES)) u_vote (
    .pred_i   (pred_i),
    .active_i (active_q),
    .ballot_o (ballot),
    .uniform_o(agree)
  );

  // path-end wins over a same-cycle branch
  assign do_end    = path_end_i && !empty;
  assign do_br     = branch_i && !path_end_i;
  assign divergent = do_br && !agree;
  assign push      = divergent && !full;
  assign flip      = do_end && (top_phase == PH_A);
  assign pop       = do_end && (top_phase == PH_B);

  simt_recon_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .push_i        (push),
    .push_saved_i  (active_q),
    .push_pending_i(active_q & ~pred_i),
    .pop_i         (pop),
    .flip_i        (flip),
    .top_saved_o   (top_saved),
    .top_pending_o (top_pending),
    .top_phase_o   (top_phase),
    .count_o       (depth_o),
    .full_o        (full),
    .empty_o       (empty)
  );

  always_comb begin
    active_d = active_q;
    if (push)      active_d = ballot;
    else if (flip) active_d = top_pending;
    else if (pop)  active_d = top_saved;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '1;
      ovf_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      if (divergent && full) ovf_q <= 1'b1;
    end
  end

  assign active_mask_o = active_q;
  assign lane_we_o     = active_q;
  assign ballot_o      = ballot;
  assign uniform_o     = do_br && agree;
  assign overflow_o    = ovf_q;
endmodule

// File: rtl/simt_branch_seq_chk.sv
module simt_branch_seq_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             branch_i,
  input logic [LANES-1:0] pred_i,
  input logic             path_end_i,
  input logic [LANES-1:0] active_mask_o,
  input logic [LANES-1:0] ballot_o,
  input logic             uniform_o,
  input logic [CW-1:0]    depth_o,
  input logic             overflow_o
);
  assert_div_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i && !path_end_i && !uniform_o && depth_o < CW'(DEPTH)
    |=> active_mask_o == $past(ballot_o) && depth_o == $past(depth_o) + CW'(1));

  assert_uniform_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uniform_o |=> $stable(active_mask_o) && $stable(depth_o));

  assert_overflow_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i && !path_end_i && !uniform_o && depth_o == CW'(DEPTH)
    |=> overflow_o && $stable(active_mask_o));

  assert_overflow_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_depth_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= CW'(DEPTH));

  assert_idle_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_end_i && depth_o == '0 |=> $stable(active_mask_o) && depth_o == '0);

  assert_end_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    path_end_i && depth_o != '0
    |=> depth_o == $past(depth_o) || depth_o == $past(depth_o) - CW'(1));
endmodule

bind simt_branch_seq simt_branch_seq_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/simt_branch_seq_tb.sv
module simt_branch_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        branch_i = 1'b0;
  logic [31:0] pred_i = '0;
  logic        path_end_i = 1'b0;
  logic [31:0] active_mask_o, lane_we_o, ballot_o;
  logic        uniform_o, overflow_o;
  logic [2:0]  depth_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] s_ballot;
  logic        s_uni;

  always #5 clk = ~clk;

  simt_branch_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .branch_i(branch_i), .pred_i(pred_i),
    .path_end_i(path_end_i), .active_mask_o(active_mask_o), .lane_we_o(lane_we_o),
    .ballot_o(ballot_o), .uniform_o(uniform_o), .depth_o(depth_o),
    .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic br, input logic [31:0] p, input logic pe);
    @(negedge clk);
    branch_i = br; pred_i = p; path_end_i = pe;
    #1;
    s_ballot = ballot_o;
    s_uni    = uniform_o;
    @(posedge clk);
    #1;
    branch_i = 1'b0; path_end_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 mask", active_mask_o, 32'hFFFF_FFFF);
    chk("R1 depth", 32'(depth_o), 0);
    chk("R1 ovf", 32'(overflow_o), 0);
    chk("R3 we", lane_we_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_uniform();
    do_reset();
    cyc(1'b1, 32'hFFFF_FFFF, 1'b0);
    chk("R4 uni all-true", 32'(s_uni), 1);
    chk("R2 ballot all", s_ballot, 32'hFFFF_FFFF);
    chk("R4 mask kept", active_mask_o, 32'hFFFF_FFFF);
    cyc(1'b1, 32'h0, 1'b0);
    chk("R4 uni all-false", 32'(s_uni), 1);
    chk("R4 depth kept", 32'(depth_o), 0);
  endtask

  task automatic t_divergent();
    do_reset();
    cyc(1'b1, 32'h1234_5678, 1'b0);
    chk("R2 ballot", s_ballot, 32'h1234_5678);
    chk("R4 not uni", 32'(s_uni), 0);
    chk("R5 mask A", active_mask_o, 32'h1234_5678);
    chk("R3 we A", lane_we_o, 32'h1234_5678);
    chk("R5 depth", 32'(depth_o), 1);
    cyc(1'b0, 32'h0, 1'b1);
    chk("R6 mask B", active_mask_o, ~32'h1234_5678);
    chk("R6 depth", 32'(depth_o), 1);
    cyc(1'b0, 32'h0, 1'b1);
    chk("R7 restore", active_mask_o, 32'hFFFF_FFFF);
    chk("R7 depth", 32'(depth_o), 0);
  endtask

  task automatic t_nested();
    do_reset();
    cyc(1'b1, 32'h0000_FFFF, 1'b0);
    cyc(1'b1, 32'hFF00_FFFF, 1'b0);
    chk("R4 inactive lanes ignored", 32'(s_uni), 1);
    chk("R2 ballot masked", s_ballot, 32'h0000_FFFF);
    cyc(1'b1, 32'hFFFF_00FF, 1'b0);
    chk("R5 inner A", active_mask_o, 32'h0000_00FF);
    chk("R5 inner depth", 32'(depth_o), 2);
    cyc(1'b0, 32'h0, 1'b1);
    chk("R6 inner B", active_mask_o, 32'h0000_FF00);
    cyc(1'b0, 32'h0, 1'b1);
    chk("R7 partial restore", active_mask_o, 32'h0000_FFFF);
    chk("R7 depth back", 32'(depth_o), 1);
  endtask

  task automatic t_overflow();
    logic [31:0] exp_seq [8];
    exp_seq = '{32'h0000_000C, 32'h0000_000F, 32'h0000_00F0, 32'h0000_00FF,
                32'h0000_FF00, 32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF};
    do_reset();
    cyc(1'b1, 32'h0000_FFFF, 1'b0);
    cyc(1'b1, 32'h0000_00FF, 1'b0);
    cyc(1'b1, 32'h0000_000F, 1'b0);
    cyc(1'b1, 32'h0000_0003, 1'b0);
    chk("R8 full depth", 32'(depth_o), 4);
    chk("R8 no ovf yet", 32'(overflow_o), 0);
    cyc(1'b1, 32'h0000_0001, 1'b0);
    chk("R8 ovf set", 32'(overflow_o), 1);
    chk("R8 mask held", active_mask_o, 32'h0000_0003);
    chk("R8 depth held", 32'(depth_o), 4);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 32'h0, 1'b1);
      chk("R7 unwind", active_mask_o, exp_seq[i]);
    end
    chk("R8 ovf sticky", 32'(overflow_o), 1);
    do_reset();
    #1;
    chk("R8 ovf cleared", 32'(overflow_o), 0);
  endtask

  task automatic t_ignore();
    do_reset();
    cyc(1'b0, 32'h0, 1'b1);
    chk("R9 idle end mask", active_mask_o, 32'hFFFF_FFFF);
    chk("R9 idle end depth", 32'(depth_o), 0);
    cyc(1'b1, 32'hAAAA_AAAA, 1'b0);
    cyc(1'b1, 32'h5555_0000, 1'b1);
    chk("R9 uni low on clash", 32'(s_uni), 0);
    chk("R9 end wins mask", active_mask_o, 32'h5555_5555);
    chk("R9 end wins depth", 32'(depth_o), 1);
  endtask

  task automatic t_cost();
    int la = 3, lb = 5, ca = 0, cb = 0;
    do_reset();
    cyc(1'b1, 32'h0F0F_0F0F, 1'b0);
    for (int i = 0; i < la; i++) begin
      if (active_mask_o == 32'h0F0F_0F0F) ca++;
      cyc(1'b0, 32'h0, i == la - 1);
    end
    chk("R10 not restored after A", active_mask_o, 32'hF0F0_F0F0);
    for (int i = 0; i < lb; i++) begin
      if (active_mask_o == 32'hF0F0_F0F0) cb++;
      cyc(1'b0, 32'h0, i == lb - 1);
    end
    chk("R10 cycles sum", 32'(ca + cb), 32'(la + lb));
    chk("R10 restored", active_mask_o, 32'hFFFF_FFFF);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_uniform();
    t_divergent();
    t_nested();
    t_overflow();
    t_ignore();
    t_cost();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule